// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers up to 32 interrupt request lines. Each line can be edge- or level-triggered. Every line has its own level register, which chooses one of two processor outputs for that line (normal `irq_o` or fast `fiq_o`), a 5-bit priority, and the trigger type. For each output, the bank picks the best unmasked pending source and latches its index where software can read it. Software then writes the control register to release the output for the next arbitration round.

A per-source mask and a bank-wide global mask gate delivery. A software test register can raise any request without touching the pins. One bank can sit behind a source input of another bank. For that use, the parameter `FIQ_EN` is cleared, so the second-level bank cannot route anything to the fast output. Software acknowledges the second-level bank before the first-level one.

The register port is a plain single-cycle port, not a stream. A write takes effect on the clock edge where `reg_we` is high. A read returns the addressed register combinationally in the same cycle. There is no back-pressure.

Top module: `intc_bank`

## Requirements
- R1: After reset:
  - all outputs are low;
  - the mask register (word 1) reads all ones;
  - the global mask (word 5) reads 1;
  - the test register (word 6) reads 0;
  - every level register reads 0.
- R2: A set bit in the mask register blocks that source. While the global mask (word 5, bit 0) is 1, no source is delivered. Writing 0 to the global mask lets unmasked pending sources through.
- R3: Source i has a level register at word address 32+i with this layout:
  - bit 0: route to the fast output;
  - bit 1: trigger type (1 edge, 0 level);
  - bits 6:2: priority.
  Reads return what was written in these bits.
- R4: Each output chooses the unmasked pending source routed to it that has the numerically lowest priority. Ties go to the lowest index. The index of the chosen source is latched when the output rises and is readable at word 2 (normal output) and word 3 (fast output).
- R5: For an edge source, a rising input sets its bit in the pending register (word 0), and the bit stays set until that source is acknowledged. For a level source, the pending bit follows the live input.
- R6: A write to the control register (word 4) acknowledges the outputs independently:
  - bit 0 acknowledges the normal output;
  - bit 1 acknowledges the fast output;
  - acknowledging an output that is not asserted has no effect;
  - word 4 reads 0.
- R7: An acknowledged output is low on the next cycle and stays low for two cycles. On the third edge after the acknowledge it rises again if a winner exists.
- R8: Once asserted, an output and its latched index hold until acknowledged, even if the request drops or the arbitration result changes.
- R9: With `FIQ_EN` = 0, bit 0 of every level register reads 0, every source goes to the normal output, and `fiq_o` never rises.
- R10: A bit set in the test register (word 6) acts as an asserted request on that source, in addition to the pin.
- R11: Word addresses 7 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_req | input | NUM_SRC | Interrupt request lines |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The bench covers these corner cases, each paired with the failure it exposes:

- **Priority ties.** Two sources share a priority. A design that broke ties toward the higher index would report source 9 instead of 5.
- **Request dropped while asserted.** A design that re-arbitrated live would drop the output or change the latched index.
- **Edge source pulsed for one cycle.** This exposes a pending bit that follows the pin, or one that is never cleared by the acknowledge.
- **Acknowledge mistimed.** An acknowledge arrives while an output is idle or in its holdoff. A design without a holdoff would re-raise the output one cycle early.
- **Second-level instance.** A second-level bank shows whether the fast route leaks through when it is forbidden.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_ADDR_W = 6;
  localparam int unsigned PRIO_W     = 5;
  localparam int unsigned LVL_W      = PRIO_W + 2;

  localparam logic [REG_ADDR_W-1:0] A_PEND   = 6'd0;
  localparam logic [REG_ADDR_W-1:0] A_MASK   = 6'd1;
  localparam logic [REG_ADDR_W-1:0] A_IRQ_ID = 6'd2;
  localparam logic [REG_ADDR_W-1:0] A_FIQ_ID = 6'd3;
  localparam logic [REG_ADDR_W-1:0] A_CTRL   = 6'd4;
  localparam logic [REG_ADDR_W-1:0] A_GMASK  = 6'd5;
  localparam logic [REG_ADDR_W-1:0] A_TEST   = 6'd6;
  localparam logic [REG_ADDR_W-1:0] A_LVL    = 6'd32;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ACTIVE = 2'd1,
    CH_HOLD   = 2'd2
  } ch_state_e;

  // bit order matches the software-visible level register
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_trig;
    logic              to_fiq;
  } lvl_cfg_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIQ_EN  = 1,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [REG_ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_SRC-1:0]      pend,
  input  logic [IDX_W-1:0]        irq_id,
  input  logic [IDX_W-1:0]        fiq_id,
  output logic [DATA_W-1:0]       rdata,
  output logic [NUM_SRC-1:0]      mask_q,
  output logic                    gmask_q,
  output logic [NUM_SRC-1:0]      test_q,
  output lvl_cfg_t [NUM_SRC-1:0]  cfg_q,
  output logic [1:0]              ack
);
  logic [NUM_SRC-1:0]    lvl_we;
  logic [REG_ADDR_W-1:0] lvl_off;
  logic                  ctrl_wr;

  assign ctrl_wr = we && (addr == A_CTRL);
  assign ack     = {ctrl_wr && wdata[1], ctrl_wr && wdata[0]};
  assign lvl_off = addr - A_LVL;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl_dec
    assign lvl_we[g] = we && (addr == A_LVL + REG_ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
      test_q  <= '0;
    end else if (we) begin
      if (addr == A_MASK)  mask_q  <= wdata[NUM_SRC-1:0];
      if (addr == A_GMASK) gmask_q <= wdata[0];
      if (addr == A_TEST)  test_q  <= wdata[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (lvl_we[i]) begin
          cfg_q[i].prio      <= wdata[2 +: PRIO_W];
          cfg_q[i].edge_trig <= wdata[1];
          cfg_q[i].to_fiq    <= (FIQ_EN != 0) && wdata[0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PEND:   rdata[NUM_SRC-1:0] = pend;
      A_MASK:   rdata[NUM_SRC-1:0] = mask_q;
      A_IRQ_ID: rdata[IDX_W-1:0]   = irq_id;
      A_FIQ_ID: rdata[IDX_W-1:0]   = fiq_id;
      A_GMASK:  rdata[0]           = gmask_q;
      A_TEST:   rdata[NUM_SRC-1:0] = test_q;
      default: begin
        if (addr >= A_LVL && lvl_off < REG_ADDR_W'(NUM_SRC))
          rdata[LVL_W-1:0] = cfg_q[lvl_off[IDX_W-1:0]];
      end
    endcase
  end
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_eff,
  input  logic [NUM_SRC-1:0] edge_cfg,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] prev_q, edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= src_eff;
      // a new rising edge in the acknowledge cycle re-arms the bit
      edge_q <= ((edge_q & ~clr) | (src_eff & ~prev_q)) & edge_cfg;
    end
  end

  assign pend = (edge_cfg & edge_q) | (~edge_cfg & src_eff);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PW      = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]         req,
  input  logic [NUM_SRC-1:0][PW-1:0] prio,
  output logic                       valid,
  output logic [IDX_W-1:0]           idx
);
  logic [PW-1:0] best;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '1;
    // strict compare keeps the lowest index on equal priority
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!valid || prio[i] < best)) begin
        valid = 1'b1;
        best  = prio[i];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_channel.sv
module intc_channel
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_valid,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic               ack,
  output logic               active,
  output logic [IDX_W-1:0]   idx_q,
  output logic [NUM_SRC-1:0] clr
);
  ch_state_e state_q;

  assign active = (state_q == CH_ACTIVE);
  assign clr    = (active && ack) ? (NUM_SRC'(1) << idx_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        CH_IDLE: if (win_valid) begin
          state_q <= CH_ACTIVE;
          idx_q   <= win_idx;
        end
        CH_ACTIVE: if (ack) state_q <= CH_HOLD;
        default:   state_q <= CH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIQ_EN  = 1,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_we,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_SRC-1:0]    irq_req,
  output logic                  irq_o,
  output logic                  fiq_o
);
  logic [NUM_SRC-1:0]             mask_q, test_q, pend, src_eff;
  logic [NUM_SRC-1:0]             edge_vec, fiq_vec, cand, clr_vec;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
  lvl_cfg_t [NUM_SRC-1:0]         cfg_q;
  logic                           gmask_q;
  logic [1:0]                     reg_ack;

  logic [NUM_SRC-1:0] ch_req [2];
  logic [NUM_SRC-1:0] ch_clr [2];
  logic [IDX_W-1:0]   win_i  [2];
  logic [IDX_W-1:0]   ch_idx [2];
  logic [1:0]         win_v, ch_out;

  intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .FIQ_EN(FIQ_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend), .irq_id(ch_idx[0]), .fiq_id(ch_idx[1]), .rdata(reg_rdata),
    .mask_q(mask_q), .gmask_q(gmask_q), .test_q(test_q), .cfg_q(cfg_q),
    .ack(reg_ack)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
    assign edge_vec[g] = cfg_q[g].edge_trig;
    assign fiq_vec[g]  = cfg_q[g].to_fiq;
    assign prio_arr[g] = cfg_q[g].prio;
  end

  assign src_eff = irq_req | test_q;

  intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_eff(src_eff), .edge_cfg(edge_vec),
    .clr(clr_vec), .pend(pend)
  );

  assign cand = gmask_q ? '0 : (pend & ~mask_q);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign ch_req[c] = (c == 0) ? (cand & ~fiq_vec) : (cand & fiq_vec);

    intc_arbiter #(.NUM_SRC(NUM_SRC), .PW(PRIO_W)) u_arb (
      .req(ch_req[c]), .prio(prio_arr), .valid(win_v[c]), .idx(win_i[c])
    );

    intc_channel #(.NUM_SRC(NUM_SRC)) u_ch (
      .clk(clk), .rst_n(rst_n), .win_valid(win_v[c]), .win_idx(win_i[c]),
      .ack(reg_ack[c]), .active(ch_out[c]), .idx_q(ch_idx[c]), .clr(ch_clr[c])
    );
  end

  assign clr_vec = ch_clr[0] | ch_clr[1];
  assign irq_o   = ch_out[0];
  assign fiq_o   = ch_out[1];
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned FIQ_EN = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_irq,
  input logic             ack_fiq,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [IDX_W-1:0] irq_idx,
  input logic             irq_win,
  input logic             fiq_win,
  input logic             gmask
);
  // R7
  irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_irq && irq_o) |=> !irq_o);

  // R7
  irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |=> !irq_o);

  // R6
  fiq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fiq && fiq_o) |=> !fiq_o);

  // R8
  irq_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(irq_o)) |-> $stable(irq_idx));

  // R4
  irq_rise_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_win));

  // R4
  fiq_rise_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(fiq_win));

  // R2
  gmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) || $rose(fiq_o)) |-> !$past(gmask));

  // R9
  fiq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FIQ_EN == 0) |-> !fiq_o);
endmodule

bind intc_bank intc_bank_chk #(.IDX_W(IDX_W), .FIQ_EN(FIQ_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_irq(reg_ack[0]), .ack_fiq(reg_ack[1]),
  .irq_o(irq_o), .fiq_o(fiq_o), .irq_idx(ch_idx[0]),
  .irq_win(win_v[0]), .fiq_win(win_v[1]), .gmask(gmask_q)
);

// File: tb/test_intc_bank.sv
module test_intc_bank;
  logic clk = 1'b0;
  always #5 clk = ~clk;  // 10 ns period

  logic        rst_n = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, src = '0, cur_src = '0;
  logic [31:0] rdata [2];
  logic        irq [2];
  logic        fiq [2];

  intc_bank #(.FIQ_EN(1)) i_intc_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata[0]), .irq_req(src), .irq_o(irq[0]), .fiq_o(fiq[0]));
  intc_bank #(.FIQ_EN(0)) i_intc_bank_l2 (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata[1]), .irq_req(src), .irq_o(irq[1]), .fiq_o(fiq[1]));

  // behavioural reference, index k = 0 first-level, 1 second-level
  int          m_prio [2][32];
  bit          m_fiq  [2][32];
  bit          m_edge [2][32];
  bit [31:0]   m_mask [2], m_test [2], m_pe [2], m_prev [2];
  bit          m_gm   [2];
  int          m_st   [2][2];
  int          m_idx  [2][2];

  int    vectors = 0, miss = 0, wd = 0;
  string tag = "R1";

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic m_reset(int k);
    m_mask[k] = '1; m_gm[k] = 1'b1; m_test[k] = '0; m_pe[k] = '0; m_prev[k] = '0;
    for (int i = 0; i < 32; i++) begin m_prio[k][i] = 0; m_fiq[k][i] = 0; m_edge[k][i] = 0; end
    for (int c = 0; c < 2; c++) begin m_st[k][c] = 0; m_idx[k][c] = 0; end
  endtask

  function automatic bit [31:0] m_pend(int k);
    bit [31:0] p;
    for (int i = 0; i < 32; i++)
      p[i] = m_edge[k][i] ? m_pe[k][i] : (src[i] | m_test[k][i]);
    return p;
  endfunction

  task automatic m_step(int k);
    bit [31:0] eff, cand, clr, edgev;
    int best;
    eff  = src | m_test[k];
    cand = m_gm[k] ? 32'h0 : (m_pend(k) & ~m_mask[k]);
    clr  = '0;
    for (int c = 0; c < 2; c++) begin
      best = -1;
      for (int i = 0; i < 32; i++)
        if (cand[i] && (m_fiq[k][i] == (c == 1)) &&
            (best < 0 || m_prio[k][i] < m_prio[k][best])) best = i;
      if (m_st[k][c] == 0) begin
        if (best >= 0) begin m_st[k][c] = 1; m_idx[k][c] = best; end
      end else if (m_st[k][c] == 1) begin
        if (we && addr == 6'd4 && wdata[c]) begin m_st[k][c] = 2; clr[m_idx[k][c]] = 1'b1; end
      end else m_st[k][c] = 0;
    end
    for (int i = 0; i < 32; i++) edgev[i] = m_edge[k][i];
    m_pe[k]   = ((m_pe[k] & ~clr) | (eff & ~m_prev[k])) & edgev;
    m_prev[k] = eff;
    if (we) begin
      if (addr == 6'd1) m_mask[k] = wdata;
      if (addr == 6'd5) m_gm[k]   = wdata[0];
      if (addr == 6'd6) m_test[k] = wdata;
      if (addr >= 6'd32) begin
        m_fiq[k][addr-32]  = wdata[0] && (k == 0);
        m_edge[k][addr-32] = wdata[1];
        m_prio[k][addr-32] = int'(wdata[6:2]);
      end
    end
  endtask

  function automatic bit [31:0] m_read(int k);
    case (addr)
      6'd0: return m_pend(k);
      6'd1: return m_mask[k];
      6'd2: return 32'(m_idx[k][0]);
      6'd3: return 32'(m_idx[k][1]);
      6'd5: return {31'h0, m_gm[k]};
      6'd6: return m_test[k];
      default:
        if (addr >= 6'd32)
          return {25'h0, 5'(m_prio[k][addr-32]), m_edge[k][addr-32], m_fiq[k][addr-32]};
        else return 32'h0;
    endcase
  endfunction

  task automatic cyc(bit w, logic [5:0] a, logic [31:0] d);
    we = w; addr = a; wdata = d; src = cur_src;
    @(posedge clk);
    for (int k = 0; k < 2; k++) if (!rst_n) m_reset(k); else m_step(k);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(tag, $sformatf("bank%0d irq_o", k), 32'(irq[k]), 32'(m_st[k][0] == 1));
      check(tag, $sformatf("bank%0d fiq_o", k), 32'(fiq[k]), 32'(m_st[k][1] == 1));
      check(tag, $sformatf("bank%0d rdata@%0d", k, a), rdata[k], m_read(k));
    end
  endtask

  task automatic rd(logic [5:0] a); cyc(1'b0, a, 32'h0); endtask
  task automatic wr(logic [5:0] a, logic [31:0] d); cyc(1'b1, a, d); endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      miss++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) m_reset(k);
    repeat (3) rd(6'd0);
    rst_n = 1'b1;

    tag = "R1";
    rd(6'd1); check("R1", "mask reset", rdata[0], 32'hffff_ffff);
    rd(6'd5); check("R1", "gmask reset", rdata[0], 32'h1);
    rd(6'd6); rd(6'd40); check("R1", "level reset", rdata[0], 32'h0);
    check("R1", "irq reset", 32'(irq[0]), 32'h0);

    tag = "R3";
    wr(6'd35, 32'h1C); wr(6'd37, 32'h08); wr(6'd41, 32'h08);
    wr(6'd44, 32'h05); wr(6'd52, 32'h12);
    rd(6'd44);
    check("R3", "level 12 readback", rdata[0], 32'h05);
    check("R9", "level 12 fiq bit forced", rdata[1], 32'h04);

    tag = "R2";
    wr(6'd1, ~32'h0010_1228);
    cur_src = 32'h8;
    repeat (3) rd(6'd2);
    check("R2", "global mask blocks", 32'(irq[0]), 32'h0);
    wr(6'd5, 32'h0); rd(6'd2); rd(6'd2);
    check("R2", "irq after gmask clear", 32'(irq[0]), 32'h1);
    check("R4", "winner index", rdata[0], 32'd3);

    tag = "R8";
    cur_src = 32'h0000_0220;
    rd(6'd2); rd(6'd2);
    check("R8", "irq held", 32'(irq[0]), 32'h1);
    check("R8", "index held", rdata[0], 32'd3);

    tag = "R7";
    wr(6'd4, 32'h1);
    check("R7", "drop after ack", 32'(irq[0]), 32'h0);
    rd(6'd2); check("R7", "second low cycle", 32'(irq[0]), 32'h0);
    rd(6'd2); check("R7", "re-raise", 32'(irq[0]), 32'h1);
    check("R4", "tie lowest index", rdata[0], 32'd5);

    tag = "R6";
    cur_src = cur_src | 32'h1000;
    rd(6'd3);
    check("R6", "fiq raised", 32'(fiq[0]), 32'h1);
    check("R4", "fiq index", rdata[0], 32'd12);
    check("R9", "no fiq on level 2", 32'(fiq[1]), 32'h0);
    wr(6'd4, 32'h2);
    check("R6", "irq untouched by fiq ack", 32'(irq[0]), 32'h1);
    check("R6", "fiq acked", 32'(fiq[0]), 32'h0);
    wr(6'd4, 32'h3); rd(6'd4);
    check("R6", "control reads zero", rdata[0], 32'h0);

    tag = "R5";
    cur_src = 32'h0;
    repeat (4) begin wr(6'd4, 32'h3); rd(6'd0); end
    cur_src = 32'h0010_0000; rd(6'd0);
    cur_src = 32'h0; rd(6'd0);
    check("R5", "edge latched", rdata[0] & 32'h0010_0000, 32'h0010_0000);
    rd(6'd2);
    check("R5", "edge source wins", rdata[0], 32'd20);
    wr(6'd4, 32'h1); rd(6'd0);
    check("R5", "edge cleared by ack", rdata[0] & 32'h0010_0000, 32'h0);

    tag = "R10";
    wr(6'd6, 32'h8); rd(6'd2); rd(6'd2);
    check("R10", "test bit raises", 32'(irq[0]), 32'h1);
    check("R10", "test index", rdata[0], 32'd3);
    wr(6'd6, 32'h0); wr(6'd4, 32'h3); rd(6'd0); rd(6'd0);

    tag = "R11";
    rd(6'd7);  check("R11", "hole 7", rdata[0], 32'h0);
    rd(6'd31); check("R11", "hole 31", rdata[0], 32'h0);

    tag = "R4";
    for (int n = 0; n < 600; n++) begin
      int r;
      if ($urandom % 5 == 0) cur_src = $urandom & $urandom & $urandom;
      r = int'($urandom % 12);
      if (r < 7)       cyc(($urandom % 3) == 0, 6'(r), $urandom & 32'hffff_fff0 | (r == 5 ? $urandom % 2 : $urandom));
      else if (r < 9)  wr(6'd4, 32'($urandom % 4));
      else             cyc(($urandom % 2) == 0, 6'd32 + 6'($urandom % 32), $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule